// File: doc/BRIEF.md
# JTAG Debug Port Scan Data Register

This block is the target-side data-register logic of a JTAG debug port. It sits behind a TAP controller, which supplies the current instruction and one-cycle capture, shift and update strobes. All of them are synchronous to the block clock. Two instruction codes select the 35-bit access register. One code reaches registers local to the debug port. The other forwards a read or write to an access port through a simple request/response link.

Every scan first captures a 3-bit acknowledge and the most recent read result. It then shifts a new request in, least significant bit first, and commits that request on update.

Reads are posted. An access-port read launched in one scan delivers its data in the capture of a later scan. A local read-buffer register hands back that stored result without starting another access-port transaction.

While an access-port transaction is still outstanding, capture reports a wait code and the request shifted in by that scan is dropped. Any other instruction bypasses the access register through a single-bit path.

Top module: `dbg_scan_dr`

## Requirements
- R1: After synchronous active-low reset, `tdo` is 0, `ap_req_valid` is 0, the stored read result is 0 and the select state is 0.
- R2: The scan frame is 35 bits, shifted least significant bit first.
  - Bit 0 is read-not-write (1 = read).
  - Bits 2:1 are register address bits 3:2.
  - Bits 34:3 are the 32-bit data word.
- R3: With the debug-port or access-port instruction selected and no access-port transaction outstanding, capture loads acknowledge 3'b010 into bits 2:0 and the stored read result into bits 34:3.
- R4: An update under the access-port instruction produces a single-cycle `ap_req_valid` in the cycle after the update strobe. The request carries:
  - `ap_req_write` = NOT read-not-write;
  - `ap_req_wdata` = the data word;
  - `ap_req_sel` = select bits 31:24;
  - `ap_req_addr` = {select bits 7:4, address bits 3:2}.
- R5: An access-port read returns its data not in its own scan but in the data field of the next scan captured after `ap_rsp_valid`. The read's own scan shows the previous result.
- R6: A debug-port read at address bits 3:2 = 2'b11 (read buffer) leaves the stored result unchanged and issues no access-port request, so repeated reads return the same word.
- R7: A debug-port write at address 2'b10 (select) stores data bits 31:24 and 7:4. A debug-port read at 2'b10 makes the next capture return those bits with all other bits zero.
- R8: Debug-port reads at addresses 2'b00 and 2'b01 set the stored result to zero. Debug-port writes there change nothing and issue no request.
- R9: If a capture happens while an access-port transaction is outstanding, the acknowledge is 3'b001. The update of that same scan is ignored: no request and no register change.
- R10: Under any instruction other than the two access codes, a 1-bit bypass register is shifted: capture loads 0 and `tdo` presents `tdi` one shift later. No request is issued and no state changes.
- R11: Access-port writes and debug-port writes do not alter the stored read result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock (TAP clock domain) |
| rst_n | input | 1 | Synchronous active-low reset |
| ir_code | input | IR_W | Current TAP instruction |
| cap_en | input | 1 | Capture strobe, one cycle |
| shift_en | input | 1 | Shift strobe, one bit per cycle |
| upd_en | input | 1 | Update strobe, one cycle |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out |
| ap_req_valid | output | 1 | Access-port request pulse |
| ap_req_write | output | 1 | Request is a write |
| ap_req_sel | output | SEL_W | Access-port select number |
| ap_req_addr | output | BANK_W+2 | Access-port register word address |
| ap_req_wdata | output | DW | Write data |
| ap_rsp_valid | input | 1 | Access-port response pulse |
| ap_rsp_rdata | input | DW | Read data returned with the response |

## Verification
The hardest state to reach from the ports is a capture that falls inside an outstanding access-port transaction, because normal scan spacing outlasts a fast responder.

The bench's responder model has a settable latency. For the wait case it is stretched well past one full scan, and a second scan is started immediately after an access-port read. This makes the capture land while the read is pending. The bench then checks the wait acknowledge and confirms that no request was counted after that scan's update. A later read-buffer scan confirms that the original read still completed.

Random operation sequences with short latencies and idle gaps then cover the posted-read ordering across mixed access types.

// File: rtl/dscan_pkg.sv
// Shared definitions for the debug scan data register.
// Assumes a 3-bit acknowledge/request header below a data word.
package dscan_pkg;
    localparam int HDR_W = 3;

    localparam logic [HDR_W-1:0] ACK_OK   = 3'b010;
    localparam logic [HDR_W-1:0] ACK_WAIT = 3'b001;

    // Local debug-port register numbers (address bits 3:2)
    typedef enum logic [1:0] {
        DPR_ZERO0  = 2'b00,
        DPR_ZERO1  = 2'b01,
        DPR_SELECT = 2'b10,
        DPR_RDBUF  = 2'b11
    } dpreg_e;
endpackage

// File: rtl/dscan_shifter.sv
// Serial shift path: the wide access register plus a 1-bit bypass.
// Assumes strobes are one-cycle enables on clk and are mutually exclusive.
module dscan_shifter #(
    parameter int FW = 35
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          scan_sel,
    input  logic          cap_en,
    input  logic          shift_en,
    input  logic [FW-1:0] cap_word,
    input  logic          tdi,
    output logic          tdo,
    output logic [FW-1:0] frame_q
);
    logic byp_q;

    // Access register: parallel load on capture, LSB-first shift otherwise
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            frame_q <= '0;
        end else if (scan_sel) begin
            if (cap_en) begin
                frame_q <= cap_word;
            end else if (shift_en) begin
                frame_q <= {tdi, frame_q[FW-1:1]};
            end
        end
    end

    // Bypass register: used for every other instruction
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            byp_q <= 1'b0;
        end else if (!scan_sel) begin
            if (cap_en) begin
                byp_q <= 1'b0;
            end else if (shift_en) begin
                byp_q <= tdi;
            end
        end
    end

    // Serial output follows the selected path
    assign tdo = scan_sel ? frame_q[0] : byp_q;
endmodule

// File: rtl/dscan_dp_regs.sv
// Local debug-port registers: select state and the stored read result.
// Assumes dp_wr, dp_rd and ap_rd_done are never high in the same cycle.
module dscan_dp_regs
    import dscan_pkg::*;
#(
    parameter int DW     = 32,
    parameter int SEL_W  = 8,
    parameter int BANK_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dp_wr,
    input  logic              dp_rd,
    input  logic [1:0]        addr,
    input  logic [DW-1:0]     wdata,
    input  logic              ap_rd_done,
    input  logic [DW-1:0]     ap_rd_data,
    output logic [SEL_W-1:0]  sel_ap,
    output logic [BANK_W-1:0] sel_bank,
    output logic [DW-1:0]     result
);
    localparam int BANK_LO = 4;
    localparam int MID_W   = DW - SEL_W - BANK_LO - BANK_W;

    logic [DW-1:0] sel_word;

    assign sel_word = {sel_ap, {MID_W{1'b0}}, sel_bank, {BANK_LO{1'b0}}};

    // Select register: written only through its own local address
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_ap   <= '0;
            sel_bank <= '0;
        end else if (dp_wr && (dpreg_e'(addr) == DPR_SELECT)) begin
            sel_ap   <= wdata[DW-1 -: SEL_W];
            sel_bank <= wdata[BANK_LO +: BANK_W];
        end
    end

    // Stored read result: fed by access-port reads and local reads
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result <= '0;
        end else if (ap_rd_done) begin
            result <= ap_rd_data;
        end else if (dp_rd) begin
            case (dpreg_e'(addr))
                DPR_SELECT: result <= sel_word;
                DPR_RDBUF:  result <= result;
                default:    result <= '0;
            endcase
        end
    end
endmodule

// File: rtl/dscan_ap_link.sv
// Request/response link toward the access port; tracks one outstanding access.
// Assumes issue is never raised while busy and a response comes at least
// one cycle after its request.
module dscan_ap_link #(
    parameter int DW    = 32,
    parameter int SEL_W = 8,
    parameter int AAW   = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             issue,
    input  logic             issue_rnw,
    input  logic [SEL_W-1:0] issue_sel,
    input  logic [AAW-1:0]   issue_addr,
    input  logic [DW-1:0]    issue_wdata,
    input  logic             ap_rsp_valid,
    input  logic [DW-1:0]    ap_rsp_rdata,
    output logic             busy,
    output logic             ap_req_valid,
    output logic             ap_req_write,
    output logic [SEL_W-1:0] ap_req_sel,
    output logic [AAW-1:0]   ap_req_addr,
    output logic [DW-1:0]    ap_req_wdata,
    output logic             rd_done,
    output logic [DW-1:0]    rd_data
);
    logic pend_rd;

    // Request pulse and payload capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ap_req_valid <= 1'b0;
            ap_req_write <= 1'b0;
            ap_req_sel   <= '0;
            ap_req_addr  <= '0;
            ap_req_wdata <= '0;
        end else begin
            ap_req_valid <= issue;
            if (issue) begin
                ap_req_write <= ~issue_rnw;
                ap_req_sel   <= issue_sel;
                ap_req_addr  <= issue_addr;
                ap_req_wdata <= issue_wdata;
            end
        end
    end

    // Outstanding-transaction tracking
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy    <= 1'b0;
            pend_rd <= 1'b0;
        end else if (issue) begin
            busy    <= 1'b1;
            pend_rd <= issue_rnw;
        end else if (ap_rsp_valid && busy) begin
            busy    <= 1'b0;
            pend_rd <= 1'b0;
        end
    end

    // Read completion forwarded to the result register
    assign rd_done = ap_rsp_valid & busy & pend_rd;
    assign rd_data = ap_rsp_rdata;
endmodule

// File: rtl/dbg_scan_dr.sv
// Debug-port scan data register top: decodes the instruction, builds the
// capture word, and on update dispatches to local registers or the access port.
// Assumes the TAP controller gives exclusive one-cycle capture/shift/update
// strobes and holds ir_code steady across a scan.
module dbg_scan_dr
    import dscan_pkg::*;
#(
    parameter int              IR_W    = 4,
    parameter logic [IR_W-1:0] DP_INSN = 4'hA,
    parameter logic [IR_W-1:0] AP_INSN = 4'hB,
    parameter int              DW      = 32,
    parameter int              SEL_W   = 8,
    parameter int              BANK_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IR_W-1:0]   ir_code,
    input  logic              cap_en,
    input  logic              shift_en,
    input  logic              upd_en,
    input  logic              tdi,
    output logic              tdo,
    output logic              ap_req_valid,
    output logic              ap_req_write,
    output logic [SEL_W-1:0]  ap_req_sel,
    output logic [BANK_W+1:0] ap_req_addr,
    output logic [DW-1:0]     ap_req_wdata,
    input  logic              ap_rsp_valid,
    input  logic [DW-1:0]     ap_rsp_rdata
);
    localparam int FW  = DW + HDR_W;
    localparam int AAW = BANK_W + 2;

    logic              is_dp, is_ap, scan_sel;
    logic              busy, wait_q, upd_go;
    logic [FW-1:0]     frame_q, cap_word;
    logic              f_rnw;
    logic [1:0]        f_addr;
    logic [DW-1:0]     f_data;
    logic [SEL_W-1:0]  sel_ap;
    logic [BANK_W-1:0] sel_bank;
    logic [DW-1:0]     result;
    logic              rd_done;
    logic [DW-1:0]     rd_data;
    logic              dp_wr, dp_rd, ap_issue;

    // Instruction decode
    assign is_dp    = (ir_code == DP_INSN);
    assign is_ap    = (ir_code == AP_INSN);
    assign scan_sel = is_dp | is_ap;

    // Capture word: stored result above the acknowledge
    assign cap_word = {result, busy ? ACK_WAIT : ACK_OK};

    // Frame field split
    assign f_rnw  = frame_q[0];
    assign f_addr = frame_q[2:1];
    assign f_data = frame_q[FW-1:HDR_W];

    // Remember whether this scan's capture reported wait
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wait_q <= 1'b0;
        end else if (cap_en && scan_sel) begin
            wait_q <= busy;
        end
    end

    // Update dispatch
    assign upd_go   = upd_en & scan_sel & ~wait_q;
    assign dp_wr    = upd_go & is_dp & ~f_rnw;
    assign dp_rd    = upd_go & is_dp & f_rnw;
    assign ap_issue = upd_go & is_ap;

    dscan_shifter #(.FW(FW)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .scan_sel (scan_sel),
        .cap_en   (cap_en),
        .shift_en (shift_en),
        .cap_word (cap_word),
        .tdi      (tdi),
        .tdo      (tdo),
        .frame_q  (frame_q)
    );

    dscan_dp_regs #(.DW(DW), .SEL_W(SEL_W), .BANK_W(BANK_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .dp_wr      (dp_wr),
        .dp_rd      (dp_rd),
        .addr       (f_addr),
        .wdata      (f_data),
        .ap_rd_done (rd_done),
        .ap_rd_data (rd_data),
        .sel_ap     (sel_ap),
        .sel_bank   (sel_bank),
        .result     (result)
    );

    dscan_ap_link #(.DW(DW), .SEL_W(SEL_W), .AAW(AAW)) u_link (
        .clk          (clk),
        .rst_n        (rst_n),
        .issue        (ap_issue),
        .issue_rnw    (f_rnw),
        .issue_sel    (sel_ap),
        .issue_addr   ({sel_bank, f_addr}),
        .issue_wdata  (f_data),
        .ap_rsp_valid (ap_rsp_valid),
        .ap_rsp_rdata (ap_rsp_rdata),
        .busy         (busy),
        .ap_req_valid (ap_req_valid),
        .ap_req_write (ap_req_write),
        .ap_req_sel   (ap_req_sel),
        .ap_req_addr  (ap_req_addr),
        .ap_req_wdata (ap_req_wdata),
        .rd_done      (rd_done),
        .rd_data      (rd_data)
    );
endmodule

// File: rtl/dscan_checker.sv
// Port-level protocol checks for dbg_scan_dr; tracks outstanding requests itself.
module dscan_checker #(
    parameter int              IR_W    = 4,
    parameter logic [IR_W-1:0] AP_INSN = 4'hB
) (
    input logic            clk,
    input logic            rst_n,
    input logic [IR_W-1:0] ir_code,
    input logic            upd_en,
    input logic            ap_req_valid,
    input logic            ap_rsp_valid
);
    logic pend_q;

    // Independent record of an outstanding access-port transaction
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
        end else if (ap_req_valid) begin
            pend_q <= 1'b1;
        end else if (ap_rsp_valid) begin
            pend_q <= 1'b0;
        end
    end

    AST_REQ_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        ap_req_valid |=> !ap_req_valid); // R4
    AST_REQ_AFTER_UPDATE: assert property (@(posedge clk) disable iff (!rst_n)
        ap_req_valid |-> $past(upd_en)); // R4
    AST_REQ_ONLY_AP_INSN: assert property (@(posedge clk) disable iff (!rst_n)
        ap_req_valid |-> ($past(ir_code) == AP_INSN)); // R10
    AST_NO_REQ_WHILE_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        ap_req_valid |-> !pend_q); // R9
endmodule

bind dbg_scan_dr dscan_checker #(.IR_W(IR_W), .AP_INSN(AP_INSN)) u_dscan_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .ir_code      (ir_code),
    .upd_en       (upd_en),
    .ap_req_valid (ap_req_valid),
    .ap_rsp_valid (ap_rsp_valid)
);

// File: tb/test_dbg_scan_dr.sv
module test_dbg_scan_dr;
    localparam logic [3:0] DPI = 4'hA;
    localparam logic [3:0] API = 4'hB;
    localparam logic [3:0] BYI = 4'h0;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  ir_code = BYI;
    logic        cap_en = 1'b0, shift_en = 1'b0, upd_en = 1'b0, tdi = 1'b0;
    logic        tdo;
    logic        ap_req_valid, ap_req_write;
    logic [7:0]  ap_req_sel;
    logic [5:0]  ap_req_addr;
    logic [31:0] ap_req_wdata;
    logic        ap_rsp_valid = 1'b0;
    logic [31:0] ap_rsp_rdata = '0;

    int total = 0;
    int bad = 0;
    int req_cnt = 0;
    int lat = 2;

    // Access-port memory model and bench-side expectation mirror
    logic [31:0] apmem [64];
    logic [31:0] tmem  [64];
    logic [7:0]  m_sel = '0;
    logic [3:0]  m_bank = '0;
    logic [31:0] m_res = '0;
    logic        lr_write;
    logic [7:0]  lr_sel;
    logic [5:0]  lr_addr;
    logic [31:0] lr_wdata;

    always #10 clk = ~clk; // 50 MHz

    dbg_scan_dr i_dbg_scan_dr (
        .clk(clk), .rst_n(rst_n), .ir_code(ir_code),
        .cap_en(cap_en), .shift_en(shift_en), .upd_en(upd_en),
        .tdi(tdi), .tdo(tdo),
        .ap_req_valid(ap_req_valid), .ap_req_write(ap_req_write),
        .ap_req_sel(ap_req_sel), .ap_req_addr(ap_req_addr),
        .ap_req_wdata(ap_req_wdata),
        .ap_rsp_valid(ap_rsp_valid), .ap_rsp_rdata(ap_rsp_rdata)
    );

    function automatic logic [31:0] init_word(input int a);
        return 32'hC0DE_0000 + 32'(a) * 32'h0000_0111;
    endfunction

    function automatic logic [31:0] ap_rd_exp(input logic [5:0] a, input logic [7:0] s);
        return tmem[a] ^ {s, 24'h0};
    endfunction

    // Responder: records requests and answers after lat cycles
    int     rcnt = 0;
    logic   rpend = 1'b0;
    always @(negedge clk) begin
        ap_rsp_valid <= 1'b0;
        if (ap_req_valid) begin
            req_cnt  <= req_cnt + 1;
            lr_write <= ap_req_write;
            lr_sel   <= ap_req_sel;
            lr_addr  <= ap_req_addr;
            lr_wdata <= ap_req_wdata;
            rpend    <= 1'b1;
            rcnt     <= lat;
        end else if (rpend) begin
            if (rcnt == 0) begin
                rpend        <= 1'b0;
                ap_rsp_valid <= 1'b1;
                if (lr_write) begin
                    apmem[lr_addr] <= lr_wdata;
                    ap_rsp_rdata   <= '0;
                end else begin
                    ap_rsp_rdata <= apmem[lr_addr] ^ {lr_sel, 24'h0};
                end
            end else begin
                rcnt <= rcnt - 1;
            end
        end
    end

    task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", rq, act, exp);
        end
    endtask

    task automatic scan(input logic [3:0] ir, input logic [34:0] din, output logic [34:0] dout);
        ir_code = ir;
        cap_en = 1'b1;
        @(negedge clk);
        cap_en = 1'b0;
        for (int i = 0; i < 35; i++) begin
            tdi = din[i];
            dout[i] = tdo;
            shift_en = 1'b1;
            @(negedge clk);
        end
        shift_en = 1'b0;
        upd_en = 1'b1;
        @(negedge clk);
        upd_en = 1'b0;
    endtask

    // kind: 0 AP write, 1 AP read, 2 select write, 3 select read,
    //       4 read buffer, 5 local read zero addr, 6 local write zero addr
    task automatic op(input int kind, input logic [1:0] a, input logic [31:0] d, input string tag);
        logic [34:0] dout;
        logic [3:0]  ir;
        logic        rnw;
        logic [1:0]  aa;
        int          rc0;
        bit          isap;
        aa = a;
        case (kind)
            0: begin ir = API; rnw = 1'b0; end
            1: begin ir = API; rnw = 1'b1; end
            2: begin ir = DPI; rnw = 1'b0; aa = 2'b10; end
            3: begin ir = DPI; rnw = 1'b1; aa = 2'b10; end
            4: begin ir = DPI; rnw = 1'b1; aa = 2'b11; end
            5: begin ir = DPI; rnw = 1'b1; aa = {1'b0, a[0]}; end
            default: begin ir = DPI; rnw = 1'b0; aa = {1'b0, a[0]}; end
        endcase
        isap = (kind <= 1);
        rc0 = req_cnt;
        scan(ir, {d, aa, rnw}, dout);
        chk(dout[2:0] == 3'b010, {tag, " R3 ack"}, 32'(dout[2:0]), 32'h2);
        chk(dout[34:3] == m_res, {tag, " R5 captured result"}, dout[34:3], m_res);
        case (kind)
            0: tmem[{m_bank, aa}] = d;
            1: m_res = ap_rd_exp({m_bank, aa}, m_sel);
            2: begin m_sel = d[31:24]; m_bank = d[7:4]; end
            3: m_res = {m_sel, 16'h0, m_bank, 4'h0};
            5: m_res = '0;
            default: ;
        endcase
        repeat (8) @(negedge clk);
        chk(req_cnt == rc0 + (isap ? 1 : 0), {tag, " R4 request count"}, 32'(req_cnt), 32'(rc0 + (isap ? 1 : 0)));
        if (isap) begin
            chk(lr_addr == {m_bank, aa} && lr_sel == m_sel && lr_write == !rnw,
                {tag, " R4 request fields"}, {18'h0, lr_write, lr_sel, lr_addr}, {18'h0, !rnw, m_sel, m_bank, aa});
            if (!rnw) chk(lr_wdata == d, {tag, " R4 wdata"}, lr_wdata, d);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [34:0] din, dout;
        int rc;
        void'($urandom(32'h5EED_1234));
        for (int i = 0; i < 64; i++) begin
            apmem[i] = init_word(i);
            tmem[i]  = init_word(i);
        end
        repeat (5) @(negedge clk);
        chk(tdo == 1'b0, "R1 tdo reset", 32'(tdo), 0);
        chk(ap_req_valid == 1'b0, "R1 req reset", 32'(ap_req_valid), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 / R3: first scan shows OK and a zero result; R8 zero read
        op(5, 2'b00, 32'hFFFF_FFFF, "R1 first scan");
        op(4, 2'b11, 32'h0, "R8 zero read result");

        // R7: select write then readback through read buffer
        op(2, 2'b10, 32'h03FF_FFA5, "R7 select write");
        op(3, 2'b10, 32'h0, "R7 select read");
        op(4, 2'b11, 32'h0, "R7 select readback");
        chk(m_res == 32'h0300_00A0, "R7 expected select word", m_res, 32'h0300_00A0);

        // R4 / R2: access-port write, address formed from bank and a[3:2]
        op(0, 2'b01, 32'h1234_5678, "R4 ap write");
        chk(lr_addr == 6'h29, "R2 address bits", 32'(lr_addr), 32'h29);

        // R5: posted read; R6: read buffer repeated with no request
        op(1, 2'b01, 32'h0, "R5 ap read");
        op(4, 2'b11, 32'h0, "R6 rdbuf first");
        chk(m_res == (32'h1234_5678 ^ 32'h0300_0000), "R5 read value", m_res, 32'h1134_5678);
        op(4, 2'b11, 32'h0, "R6 rdbuf repeat");

        // R11: writes leave the stored result alone
        op(0, 2'b10, 32'hDEAD_BEEF, "R11 ap write");
        op(2, 2'b10, 32'h0500_0010, "R11 select write");
        op(4, 2'b11, 32'h0, "R11 result kept");

        // R8: local write to zero address has no effect on select
        op(6, 2'b00, 32'hFFFF_FFFF, "R8 zero write");
        op(3, 2'b10, 32'h0, "R8 select intact");
        op(5, 2'b01, 32'h0, "R8 addr01 read");
        op(4, 2'b11, 32'h0, "R8 zero result");

        // R9: long latency; second scan captures wait and is dropped
        lat = 80;
        rc = req_cnt;
        scan(API, {32'h0, 2'b00, 1'b1}, dout);
        m_res = ap_rd_exp({m_bank, 2'b00}, m_sel);
        scan(API, {32'hAAAA_5555, 2'b11, 1'b0}, dout);
        chk(dout[2:0] == 3'b001, "R9 wait ack", 32'(dout[2:0]), 32'h1);
        repeat (120) @(negedge clk);
        chk(req_cnt == rc + 1, "R9 ignored request", 32'(req_cnt), 32'(rc + 1));
        lat = 2;
        op(4, 2'b11, 32'h0, "R9 recovery");
        op(4, 2'b11, 32'h0, "R9 read completed");
        op(1, 2'b11, 32'h0, "R9 ignored write absent");
        op(4, 2'b11, 32'h0, "R9 ignored write check");

        // R10: bypass path under another instruction
        rc = req_cnt;
        din = {3'b101, 32'h9C3E_71A5};
        scan(BYI, din, dout);
        chk(dout == {din[33:0], 1'b0}, "R10 bypass delay", dout[31:0], {din[30:0], 1'b0});
        repeat (8) @(negedge clk);
        chk(req_cnt == rc, "R10 no request", 32'(req_cnt), 32'(rc));
        op(4, 2'b11, 32'h0, "R10 state kept");

        // R2: random mix of operations and latencies
        for (int n = 0; n < 80; n++) begin
            int k;
            k = $urandom_range(0, 6);
            lat = $urandom_range(0, 3);
            op(k, 2'($urandom_range(0, 3)), $urandom(), "R2 random");
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule